// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host port and an external asynchronous static RAM of 512K bytes. The host issues one word access at a time: it raises a request with an address, a write flag and write data. The sequencer then drives the memory address and the three active-low strobes (chip select, output enable and write enable) with registered outputs. It also controls a split data path made of an output value, an output enable and an input sample. When the access is complete, the sequencer pulses ready for one clock cycle. For a read, the returned byte is held in a host-side register.

Each minimum the memory needs in nanoseconds is turned into a whole number of clock cycles from the clock-period parameter. Each count is rounded up and is never less than one. Every access is followed by a bus turnaround gap, so that the memory's output release window cannot overlap the controller's own drive. Whenever no request is pending, chip select stays high and the memory rests in standby. A build option keeps output enable low through write pulses. In that case, the data drive is delayed inside the pulse and the pulse is stretched to match.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and in every cycle without an access in progress, chip select, output enable and write enable are high (1), the data drive enable is 0 and ready is 0.
- R2: A read holds chip select and output enable low and write enable high for RD_CYC cycles. RD_CYC is the largest of ceil(55/T), ceil(55/T) and ceil(30/T), where T is the clock period in ns. The address stays stable for the whole read. The memory input is sampled on the last of these cycles and presented on host_rdata.
- R3: A write holds chip select and write enable low together for WR_CYC cycles. WR_CYC is the largest of ceil(40/T), ceil(50/T), ceil(55/T) and the data-setup term. The address and write data stay stable throughout. The controller drives the data bus only while write enable is low.
- R4: With output enable kept low during writes (OE_LOW_WR=1), the controller starts driving the bus TA_CYC cycles after write enable falls. The pulse then lasts at least TA_CYC+ceil(25/T) and ceil(45/T) cycles. With OE_LOW_WR=0, the drive starts with the pulse and lasts at least ceil(25/T) cycles.
- R5: After every access, all strobes stay high and the bus is not driven for TA_CYC=ceil(20/T) cycles before the next access can begin. In this gap, the controller never drives while the memory may still be driving.
- R6: Ready is high for exactly one cycle per access. Counted from the request-sampling edge, it rises RD_CYC (read) or WR_CYC (write) edges later. A request still held after ready is served as a new access, which starts TA_CYC+1 edges after that ready.
- R7: A read returns the byte most recently written to the same 19-bit address.
- R8: Every derived cycle count (RD_CYC, WR_CYC, TA_CYC) is at least 1 for any clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, sampled while idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last byte read |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dout | output | 8 | Value to drive on the data bus |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_din | input | 8 | Value sampled from the data bus |

## Verification
Two things can fall in the same cycle: the end of one access (strobe release plus the ready pulse) and the arrival of the next request. The bench provokes this by holding the request high across ready, including a read followed at once by a write. It then checks that the second ready lands exactly TA_CYC+1 plus the access length after the first. Two behavioural memories, one for each output-enable variant, watch every negative edge. They flag any overlap of controller drive with the memory's driving or release window, and they also flag any strobe pulse shorter than its cycle count.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_TURN  = 2'd3
    } st_e;

    // Round a nanosecond minimum up to whole clock cycles, never below one.
    function automatic int ns2cyc(input int ns, input int per_ns);
        int c;
        c = (ns + per_ns - 1) / per_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             last,
    output logic [CNT_W-1:0] age
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign last = tmr_q.run && (tmr_q.cnt == tmr_q.len - 1'b1);
    assign age  = tmr_q.cnt;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
            tmr_d.len = len;
        end else if (tmr_q.run) begin
            if (last) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R8: a phase is never loaded with a zero length
    p_len_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        start |-> (len != '0));

    // R8: a running phase always ends before the counter can pass its length
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        tmr_q.run |-> (tmr_q.cnt < tmr_q.len));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int AW      = 19,
    parameter int DW      = 8,
    parameter int CNT_W   = 3,
    parameter int DRV_DLY = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [AW-1:0]    in_addr,
    input  logic [DW-1:0]    in_wdata,
    input  logic             we_low_d,
    input  logic [CNT_W-1:0] age_d,
    input  logic             capture,
    input  logic [DW-1:0]    mem_din,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_dout,
    output logic             mem_dq_oe,
    output logic [DW-1:0]    host_rdata
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          drive;
        logic [DW-1:0] rdata;
    } dp_t;

    dp_t dp_d, dp_q;
    logic drive_next;

    generate
        if (DRV_DLY == 0) begin : g_drv_now
            assign drive_next = we_low_d;
        end else begin : g_drv_late
            localparam logic [CNT_W-1:0] DLY = CNT_W'(DRV_DLY);
            assign drive_next = we_low_d && (age_d >= DLY);
        end
    endgenerate

    always_comb begin
        dp_d       = dp_q;
        dp_d.drive = drive_next;
        if (accept) begin
            dp_d.addr  = in_addr;
            dp_d.wdata = in_wdata;
        end
        if (capture) begin
            dp_d.rdata = mem_din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign mem_addr   = dp_q.addr;
    assign mem_dout   = dp_q.wdata;
    assign mem_dq_oe  = dp_q.drive;
    assign host_rdata = dp_q.rdata;

    // R3: data held steady while it is being driven
    p_wdata_steady_r3: assert property (@(posedge clk) disable iff (rst)
        (dp_q.drive && $past(dp_q.drive)) |-> $stable(dp_q.wdata));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
    parameter int AW        = 19,
    parameter int DW        = 8,
    parameter int CLK_NS    = 20,
    parameter int RC_NS     = 55,
    parameter int AA_NS     = 55,
    parameter int OE_NS     = 30,
    parameter int WP_NS     = 40,
    parameter int CW_NS     = 50,
    parameter int AWE_NS    = 50,
    parameter int WC_NS     = 55,
    parameter int DS_NS     = 25,
    parameter int HZ_NS     = 20,
    parameter bit OE_LOW_WR = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_ready,
    output logic [DW-1:0] host_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_din
);
    import asram_pkg::*;

    localparam int RD_CYC  = imax(ns2cyc(RC_NS, CLK_NS),
                                  imax(ns2cyc(AA_NS, CLK_NS), ns2cyc(OE_NS, CLK_NS)));
    localparam int TA_CYC  = ns2cyc(HZ_NS, CLK_NS);
    localparam int DRV_DLY = OE_LOW_WR ? TA_CYC : 0;
    localparam int WR_BASE = imax(imax(ns2cyc(WP_NS, CLK_NS), ns2cyc(CW_NS, CLK_NS)),
                                  imax(ns2cyc(AWE_NS, CLK_NS), ns2cyc(WC_NS, CLK_NS)));
    localparam int WR_DATA = DRV_DLY + ns2cyc(DS_NS, CLK_NS);
    localparam int WR_OEL  = OE_LOW_WR ? ns2cyc(DS_NS + HZ_NS, CLK_NS) : 1;
    localparam int WR_CYC  = imax(WR_BASE, imax(WR_DATA, WR_OEL));
    localparam int MAXC    = imax(RD_CYC, imax(WR_CYC, TA_CYC));
    localparam int CNT_W   = $clog2(MAXC + 1);

    localparam logic [CNT_W-1:0] LEN_RD = CNT_W'(RD_CYC);
    localparam logic [CNT_W-1:0] LEN_WR = CNT_W'(WR_CYC);
    localparam logic [CNT_W-1:0] LEN_TA = CNT_W'(TA_CYC);

    typedef struct packed {
        st_e  st;
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic rdy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tm_start;
    logic [CNT_W-1:0] tm_len;
    logic             tm_last;
    logic [CNT_W-1:0] tm_age;
    logic             accept;
    logic             capture;
    logic             we_low_d;
    logic [CNT_W-1:0] age_d;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (tm_start),
        .len   (tm_len),
        .last  (tm_last),
        .age   (tm_age)
    );

    asram_datapath #(
        .AW      (AW),
        .DW      (DW),
        .CNT_W   (CNT_W),
        .DRV_DLY (DRV_DLY)
    ) u_dp (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .in_addr    (host_addr),
        .in_wdata   (host_wdata),
        .we_low_d   (we_low_d),
        .age_d      (age_d),
        .capture    (capture),
        .mem_din    (mem_din),
        .mem_addr   (mem_addr),
        .mem_dout   (mem_dout),
        .mem_dq_oe  (mem_dq_oe),
        .host_rdata (host_rdata)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rdy = 1'b0;
        tm_start  = 1'b0;
        tm_len    = LEN_TA;
        accept    = 1'b0;
        capture   = 1'b0;
        we_low_d  = 1'b0;
        age_d     = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (host_req) begin
                    accept     = 1'b1;
                    tm_start   = 1'b1;
                    ctl_d.cs_n = 1'b0;
                    if (host_we) begin
                        ctl_d.st   = ST_WRITE;
                        ctl_d.we_n = 1'b0;
                        ctl_d.oe_n = !OE_LOW_WR;
                        tm_len     = LEN_WR;
                        we_low_d   = 1'b1;
                        age_d      = '0;
                    end else begin
                        ctl_d.st   = ST_READ;
                        ctl_d.oe_n = 1'b0;
                        tm_len     = LEN_RD;
                    end
                end
            end
            ST_READ: begin
                if (tm_last) begin
                    capture    = 1'b1;
                    tm_start   = 1'b1;
                    tm_len     = LEN_TA;
                    ctl_d.st   = ST_TURN;
                    ctl_d.cs_n = 1'b1;
                    ctl_d.oe_n = 1'b1;
                    ctl_d.rdy  = 1'b1;
                end
            end
            ST_WRITE: begin
                if (tm_last) begin
                    tm_start   = 1'b1;
                    tm_len     = LEN_TA;
                    ctl_d.st   = ST_TURN;
                    ctl_d.cs_n = 1'b1;
                    ctl_d.oe_n = 1'b1;
                    ctl_d.we_n = 1'b1;
                    ctl_d.rdy  = 1'b1;
                end else begin
                    we_low_d = 1'b1;
                    age_d    = tm_age + 1'b1;
                end
            end
            ST_TURN: begin
                if (tm_last) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.cs_n <= 1'b1;
            ctl_q.oe_n <= 1'b1;
            ctl_q.we_n <= 1'b1;
            ctl_q.rdy  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_cs_n   = ctl_q.cs_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_we_n   = ctl_q.we_n;
    assign host_ready = ctl_q.rdy;

    // R1: a deselected memory sees no other strobe and no drive
    p_standby_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

    // R3: bus driven only inside a write pulse
    p_drive_in_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && !mem_cs_n));

    // R2, R3: the address does not move while the memory is selected
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R5: release of chip select is followed by at least one quiet cycle
    p_turnaround_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cs_n) |=> (mem_cs_n && !mem_dq_oe));

    // R6: ready is a single-cycle pulse
    p_ready_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready);

    // R6: ready follows a strobe release
    p_ready_on_release_r6: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> ($past(!mem_cs_n) && mem_cs_n));

    generate
        if (OE_LOW_WR) begin : g_chk_oel
            // R4: no drive on the cycle write enable falls
            p_late_drive_r4: assert property (@(posedge clk) disable iff (rst)
                $fell(mem_we_n) |-> !mem_dq_oe);
        end else begin : g_chk_oeh
            // R2: output enable and write enable never low together
            p_no_oe_we_r2: assert property (@(posedge clk) disable iff (rst)
                !mem_oe_n |-> mem_we_n);
        end
    endgenerate

endmodule

// File: tb/asram_ctrl_test.sv
module asram_mem_bhv #(
    parameter int CLK_NS = 20,
    parameter bit OE_LOW = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [18:0] addr,
    input  logic        cs_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [7:0]  dout,
    input  logic        dq_oe,
    output logic [7:0]  din,
    output int          v_rd,
    output int          v_wr,
    output int          v_bus
);
    logic [7:0] mem [int];
    int  rd_age, wp_cyc, ds_cyc, hz_left;
    bit  prev_drv, oe_seen;
    logic [18:0] rd_addr, wr_addr;
    logic [7:0]  last_d;
    int hz_cyc;

    initial hz_cyc = (20 + CLK_NS - 1) / CLK_NS;

    always @(negedge clk) begin
        if (rst) begin
            rd_age = 0; wp_cyc = 0; ds_cyc = 0; hz_left = 0;
            prev_drv = 0; oe_seen = 0; v_rd = 0; v_wr = 0; v_bus = 0;
            din = 8'hEE; last_d = 8'h00; rd_addr = '0; wr_addr = '0;
        end else begin : run
            bit drv;
            drv = !cs_n && !oe_n && we_n;
            if (prev_drv && !drv) hz_left = hz_cyc;
            if (dq_oe && (drv || hz_left > 0)) begin
                v_bus++;
                $display("model: bus clash at %0t", $time);
            end
            if (hz_left > 0 && !(prev_drv && !drv && hz_left == hz_cyc && 0)) hz_left--;
            prev_drv = drv;
            // read phase
            if (drv) begin
                if (rd_age == 0) rd_addr = addr;
                else if (addr != rd_addr) v_rd++;
                rd_age++;
            end else begin
                if (rd_age > 0 && rd_age * CLK_NS < 55) begin
                    v_rd++;
                    $display("model: short read %0d", rd_age);
                end
                rd_age = 0;
            end
            // write phase
            if (!cs_n && !we_n) begin
                if (wp_cyc == 0) begin wr_addr = addr; oe_seen = 0; end
                else if (addr != wr_addr) v_wr++;
                if (!oe_n) oe_seen = 1;
                wp_cyc++;
                if (dq_oe) begin
                    if (ds_cyc > 0 && dout == last_d) ds_cyc++;
                    else ds_cyc = 1;
                    last_d = dout;
                end else begin
                    ds_cyc = 0;
                end
            end else if (wp_cyc > 0) begin
                if (wp_cyc * CLK_NS < 55 || ds_cyc * CLK_NS < 25 ||
                    (oe_seen && wp_cyc * CLK_NS < 45)) begin
                    v_wr++;
                    $display("model: short write pulse %0d setup %0d", wp_cyc, ds_cyc);
                end
                mem[int'(wr_addr)] = last_d;
                wp_cyc = 0; ds_cyc = 0;
            end
            if (drv && rd_age * CLK_NS >= 55)
                din = mem.exists(int'(addr)) ? mem[int'(addr)] : 8'h00;
            else
                din = 8'hEE;
        end
    end
endmodule

module asram_ctrl_test;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        req = 1'b0, we = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;

    logic        rdy_a, rdy_b, cs_a, cs_b, oe_a, oe_b, wen_a, wen_b, dqoe_a, dqoe_b;
    logic [7:0]  rd_a, rd_b, do_a, do_b, di_a, di_b;
    logic [18:0] ma_a, ma_b;
    int vr_a, vw_a, vb_a, vr_b, vw_b, vb_b;

    asram_ctrl #(.CLK_NS(T), .OE_LOW_WR(1'b0)) uut (
        .clk(clk), .rst(rst), .host_req(req), .host_we(we), .host_addr(addr),
        .host_wdata(wdata), .host_ready(rdy_a), .host_rdata(rd_a),
        .mem_addr(ma_a), .mem_cs_n(cs_a), .mem_oe_n(oe_a), .mem_we_n(wen_a),
        .mem_dout(do_a), .mem_dq_oe(dqoe_a), .mem_din(di_a));

    asram_ctrl #(.CLK_NS(T), .OE_LOW_WR(1'b1)) uut_oel (
        .clk(clk), .rst(rst), .host_req(req), .host_we(we), .host_addr(addr),
        .host_wdata(wdata), .host_ready(rdy_b), .host_rdata(rd_b),
        .mem_addr(ma_b), .mem_cs_n(cs_b), .mem_oe_n(oe_b), .mem_we_n(wen_b),
        .mem_dout(do_b), .mem_dq_oe(dqoe_b), .mem_din(di_b));

    asram_mem_bhv #(.CLK_NS(T), .OE_LOW(1'b0)) m_a (
        .clk(clk), .rst(rst), .addr(ma_a), .cs_n(cs_a), .oe_n(oe_a), .we_n(wen_a),
        .dout(do_a), .dq_oe(dqoe_a), .din(di_a), .v_rd(vr_a), .v_wr(vw_a), .v_bus(vb_a));

    asram_mem_bhv #(.CLK_NS(T), .OE_LOW(1'b1)) m_b (
        .clk(clk), .rst(rst), .addr(ma_b), .cs_n(cs_b), .oe_n(oe_b), .we_n(wen_b),
        .dout(do_b), .dq_oe(dqoe_b), .din(di_b), .v_rd(vr_b), .v_wr(vw_b), .v_bus(vb_b));

    function automatic int cyc(input int ns);
        int c = (ns + T - 1) / T;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    int rd_exp, ta_exp, wr_exp_a, wr_exp_b;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
    endfunction

    // one access on both instances; returns read data and latencies
    task automatic access(input bit w, input logic [18:0] a, input logic [7:0] d,
                          output logic [7:0] ra, output logic [7:0] rb,
                          output int la, output int lb);
        int n;
        bit ga, gb;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        ga = 0; gb = 0; la = -1; lb = -1; n = 0;
        while (!(ga && gb) && n < 60) begin
            @(negedge clk);
            n++;
            if (rdy_a && !ga) begin ga = 1; la = n; ra = rd_a; end
            if (rdy_b && !gb) begin gb = 1; lb = n; rb = rd_b; end
            if (ga && gb) req = 1'b0;
        end
        req = 1'b0;
        @(negedge clk);
        // R6: pulse is one cycle wide
        check(!rdy_a && !rdy_b, "R6 ready width", {rdy_a, rdy_b}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [18:0] alist [0:20];
        logic [7:0]  ra, rb;
        int la, lb;

        rd_exp   = mx(cyc(55), mx(cyc(55), cyc(30)));
        ta_exp   = cyc(20);
        wr_exp_a = mx(mx(mx(cyc(40), cyc(50)), mx(cyc(50), cyc(55))), cyc(25));
        wr_exp_b = mx(wr_exp_a, mx(ta_exp + cyc(25), cyc(45)));

        // R8: counts never zero
        check(rd_exp >= 1 && ta_exp >= 1 && wr_exp_a >= 1, "R8 counts", rd_exp, 1);

        repeat (3) @(negedge clk);
        // R1: reset state
        check(cs_a && oe_a && wen_a && !dqoe_a && !rdy_a, "R1 reset a",
              {cs_a, oe_a, wen_a, dqoe_a, rdy_a}, 5'b11100);
        check(cs_b && oe_b && wen_b && !dqoe_b && !rdy_b, "R1 reset b",
              {cs_b, oe_b, wen_b, dqoe_b, rdy_b}, 5'b11100);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(cs_a && oe_a && wen_a && !dqoe_a, "R1 idle", {cs_a, oe_a, wen_a, dqoe_a}, 4'b1110);

        for (int i = 0; i < 19; i++) alist[i] = 19'(1) << i;
        alist[19] = '0;
        alist[20] = 19'h7FFFF;

        // R3, R4: write sweep with latency check
        for (int i = 0; i < 21; i++) begin
            access(1'b1, alist[i], pat(alist[i]), ra, rb, la, lb);
            check(la == wr_exp_a + 1, "R3 write latency", la, wr_exp_a + 1);
            check(lb == wr_exp_b + 1, "R4 write latency oe-low", lb, wr_exp_b + 1);
        end
        // R2, R7: read back sweep
        for (int i = 0; i < 21; i++) begin
            access(1'b0, alist[i], 8'h00, ra, rb, la, lb);
            check(la == rd_exp + 1, "R2 read latency", la, rd_exp + 1);
            check(ra == pat(alist[i]), "R7 readback a", ra, pat(alist[i]));
            check(rb == pat(alist[i]), "R7 readback b", rb, pat(alist[i]));
        end
        // R7: overwrite then read
        access(1'b1, 19'h00001, 8'hC3, ra, rb, la, lb);
        access(1'b0, 19'h00001, 8'h00, ra, rb, la, lb);
        check(ra == 8'hC3 && rb == 8'hC3, "R7 overwrite", ra, 8'hC3);

        // R6, R5: request held across ready, read then write
        begin : held
            int n, first, second;
            @(negedge clk);
            req = 1'b1; we = 1'b0; addr = 19'h00002; n = 0; first = -1; second = -1;
            while (second < 0 && n < 80) begin
                @(negedge clk);
                n++;
                if (rdy_a) begin
                    if (first < 0) begin
                        first = n;
                        check(rd_a == pat(19'h00002), "R7 held read", rd_a, pat(19'h00002));
                        we = 1'b1; wdata = 8'h3C; addr = 19'h00003;
                    end else begin
                        second = n;
                    end
                end
                if (first > 0 && n == first + 1)
                    check(cs_a && !dqoe_a, "R5 turnaround quiet", {cs_a, dqoe_a}, 2'b10);
            end
            req = 1'b0;
            check(second - first == ta_exp + 1 + wr_exp_a, "R6 back-to-back gap",
                  second - first, ta_exp + 1 + wr_exp_a);
        end
        repeat (4) @(negedge clk);
        access(1'b0, 19'h00003, 8'h00, ra, rb, la, lb);
        check(ra == 8'h3C, "R7 held write", ra, 8'h3C);

        // R1: long idle stays in standby
        begin : idle
            bit ok = 1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!cs_a || !cs_b || dqoe_a || dqoe_b) ok = 0;
            end
            check(ok, "R1 standby", ok, 1);
        end

        // model-side strobe and bus checks
        check(vr_a == 0 && vr_b == 0, "R2 read strobe timing", vr_a + vr_b, 0);
        check(vw_a == 0, "R3 write pulse timing", vw_a, 0);
        check(vw_b == 0, "R4 oe-low write pulse", vw_b, 0);
        check(vb_a == 0 && vb_b == 0, "R5 bus contention", vb_a + vb_b, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule